// File: doc/BRIEF.md
# Split-Aware Fixed-Priority Bus Arbiter

This block is the single central arbiter of a multi-master pipelined system bus. Each master raises a request line. The arbiter hands the bus to exactly one master through a one-hot grant vector, and it reports the owning master's number. It moves ownership only on a clock edge where the bus ready signal is high, so the reported number always lines up with the address phase in progress. Masters without a grant stall in their address phase.

Slaves can defer a transfer with a SPLIT response. When that happens, the arbiter parks the master whose data phase received the response. A parked master is left out of arbitration, and the bus passes to the next requester. Slaves later drive a resume vector, which the arbiter samples on every clock. Each set bit releases the matching master. A released master wins back the bus only under the normal fixed priority, where master 0 ranks highest. When no eligible master requests, master 0 holds the bus as the default owner.

Top module: `split_prio_arbiter`

## Requirements
- R1: After a synchronous active-low reset, grant is one-hot on master 0, the owner number is 0, and no master is parked.
- R2: At all times exactly one grant bit is set, and it is the bit whose index equals the owner number.
- R3: Grant and owner change only on a rising edge where `bus_ready` is high. While `bus_ready` is low they hold.
- R4: On a rising edge with `bus_ready` high, the owner becomes the lowest-numbered master that is requesting and not parked.
- R5: If no master is both requesting and not parked on a rising edge with `bus_ready` high, ownership goes to master 0.
- R6: On an edge where `bus_ready` is high and `slv_resp` is 2'b11 (SPLIT), the data-phase master is parked. The data-phase master is the owner before the previous ready-high edge. Parking takes effect in that same edge's arbitration. The parked master is not chosen by R4 while it stays parked.
- R7: A set bit in `split_resume` at a clock edge unparks the matching master. That master takes part in the arbitration at the same edge.
- R8: If one master is both parked by R6 and resumed by R7 at the same edge, it ends up not parked.
- R9: The responses 2'b00 (OKAY), 2'b01 (ERROR) and 2'b10 (RETRY) park no master, and neither does a SPLIT seen while `bus_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_req | input | NUM_MASTERS | Per-master bus request |
| bus_ready | input | 1 | High when the current data phase completes |
| slv_resp | input | 2 | Response of the current data phase: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |
| split_resume | input | NUM_MASTERS | Per-master resume request from slaves |
| mst_grant | output | NUM_MASTERS | One-hot grant |
| owner_id | output | max(1,clog2(NUM_MASTERS)) | Number of the granting master (address phase) |

## Verification
The hardest case to reach is the same-edge collision. It needs a SPLIT response on a ready-high edge, aimed at the master that owned the bus one ready edge earlier, while the resume bit for that same master is set. The directed phase builds this deliberately. It first gives master 0 two ready edges so that master 0 is both owner and data-phase master. It then applies SPLIT and resume together while master 1 also requests, so a wrong result would show up as a grant moving to master 1. A long arithmetic sweep then mixes stalls, all four response codes and resume patterns, and compares every cycle against a reference computed in the bench.

// File: rtl/arb_pkg.sv
// Package: shared response encoding for the split-aware arbiter.
// Assumes the two-bit slave response code of a pipelined system bus.
package arb_pkg;
    typedef enum logic [1:0] {
        RSP_OKAY  = 2'b00,
        RSP_ERROR = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_SPLIT = 2'b11
    } rsp_code_t;
endpackage

// File: rtl/prio_pick.sv
// Module: prio_pick
// Finds the lowest set index of a request vector (index 0 wins).
// Purely combinational; 'found' is low when the vector is all zero,
// in which case 'idx' is 0.
module prio_pick #(
    parameter int WIDTH = 4,
    parameter int IW    = 2
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IW-1:0]    idx,
    output logic             found
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/split_mask.sv
// Module: split_mask
// Keeps one "parked" bit per master. A SPLIT response on a ready-high
// edge sets the bit of the data-phase master; a resume bit clears it,
// and a clear overrides a set in the same cycle. mask_nxt is exported
// so that arbitration at the same edge already sees the update.
// Assumes dphase_id < WIDTH.
module split_mask #(
    parameter int WIDTH = 4,
    parameter int IW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_ready,
    input  logic [1:0]       slv_resp,
    input  logic [IW-1:0]    dphase_id,
    input  logic [WIDTH-1:0] split_resume,
    output logic [WIDTH-1:0] mask_nxt,
    output logic [WIDTH-1:0] mask_q
);
    import arb_pkg::*;

    logic             split_hit;
    logic [WIDTH-1:0] set_vec;

    // Detect a completing SPLIT response.
    always_comb split_hit = bus_ready && (rsp_code_t'(slv_resp) == RSP_SPLIT);

    // One-hot set vector for the data-phase master; resume clears last.
    always_comb begin
        set_vec = '0;
        if (split_hit) set_vec[dphase_id] = 1'b1;
        mask_nxt = (mask_q | set_vec) & ~split_resume;
    end

    // Parked-master register.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_nxt;
    end

    // R6: a completing SPLIT without resume parks the data-phase master.
    a_r6_split_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (split_hit && !split_resume[dphase_id]) |=> mask_q[$past(dphase_id)]);

    // R8 / R7: any resumed master is unparked after the edge.
    a_r8_resume_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|split_resume) |=> ((mask_q & $past(split_resume)) == '0));

    // R9: no new parked bit appears without a completing SPLIT.
    a_r9_no_park_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !split_hit |=> ((mask_q & ~$past(mask_q)) == '0));
endmodule

// File: rtl/split_prio_arbiter.sv
// Module: split_prio_arbiter (top)
// Central fixed-priority arbiter (master 0 highest) for up to 16 masters.
// Masters parked by a SPLIT response are skipped until resumed. Ownership
// moves only on a ready-high edge; with no eligible requester master 0
// is the default owner. Assumes 1 <= NUM_MASTERS <= 16.
module split_prio_arbiter #(
    parameter int NUM_MASTERS = 4
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic [NUM_MASTERS-1:0]                           mst_req,
    input  logic                                             bus_ready,
    input  logic [1:0]                                       slv_resp,
    input  logic [NUM_MASTERS-1:0]                           split_resume,
    output logic [NUM_MASTERS-1:0]                           mst_grant,
    output logic [(NUM_MASTERS > 1 ? $clog2(NUM_MASTERS) : 1)-1:0] owner_id
);
    localparam int IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

    logic [IW-1:0]          dphase_q;
    logic [NUM_MASTERS-1:0] mask_nxt;
    logic [NUM_MASTERS-1:0] mask_q;
    logic [NUM_MASTERS-1:0] eligible;
    logic [IW-1:0]          win_idx;
    logic                   win_found;
    logic [IW-1:0]          next_owner;
    logic [NUM_MASTERS-1:0] next_grant;

    split_mask #(.WIDTH(NUM_MASTERS), .IW(IW)) u_mask (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_ready    (bus_ready),
        .slv_resp     (slv_resp),
        .dphase_id    (dphase_q),
        .split_resume (split_resume),
        .mask_nxt     (mask_nxt),
        .mask_q       (mask_q)
    );

    // Requests from masters that will not be parked after this edge.
    always_comb eligible = mst_req & ~mask_nxt;

    prio_pick #(.WIDTH(NUM_MASTERS), .IW(IW)) u_pick (
        .vec   (eligible),
        .idx   (win_idx),
        .found (win_found)
    );

    // Winner, or master 0 as default owner.
    always_comb begin
        next_owner = win_found ? win_idx : '0;
        next_grant = '0;
        next_grant[next_owner] = 1'b1;
    end

    // Ownership and data-phase tracking, advanced only when ready is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_id  <= '0;
            mst_grant <= NUM_MASTERS'(1);
            dphase_q  <= '0;
        end else if (bus_ready) begin
            owner_id  <= next_owner;
            mst_grant <= next_grant;
            dphase_q  <= owner_id;
        end
    end

    // R2: exactly one grant, matching the owner number.
    a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mst_grant) == 1) && mst_grant[owner_id]);

    // R3: a stalled bus keeps its owner.
    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> ($stable(owner_id) && $stable(mst_grant)));

    // R4/R6: when someone eligible requests, the grant lands on one of them.
    a_r4_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && (|eligible)) |=> ((mst_grant & $past(eligible)) != '0));

    // R5: nobody eligible means master 0 owns the bus.
    a_r5_default_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && !(|eligible)) |=> (owner_id == '0));
endmodule

// File: tb/split_prio_arbiter_test.sv
module split_prio_arbiter_test;
    localparam int N  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  mst_req;
    logic          bus_ready;
    logic [1:0]    slv_resp;
    logic [N-1:0]  split_resume;
    logic [N-1:0]  mst_grant;
    logic [IW-1:0] owner_id;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference state computed from the requirements.
    logic [N-1:0]  m_mask;
    logic [IW-1:0] m_owner;
    logic [IW-1:0] m_dph;

    split_prio_arbiter #(.NUM_MASTERS(N)) uut (
        .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .bus_ready(bus_ready),
        .slv_resp(slv_resp), .split_resume(split_resume),
        .mst_grant(mst_grant), .owner_id(owner_id)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; mst_req = '0; bus_ready = 1'b0; slv_resp = 2'b00; split_resume = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_mask = '0; m_owner = '0; m_dph = '0;
    endtask

    // Drive one cycle at a falling edge, update the model, check at the next falling edge.
    task automatic cyc(input logic [N-1:0] rq, input logic rdy, input logic [1:0] rs,
                       input logic [N-1:0] res, input string tag, input int exp_owner);
        logic [N-1:0]  setv, nm, el;
        logic [IW-1:0] win;
        mst_req = rq; bus_ready = rdy; slv_resp = rs; split_resume = res;
        setv = '0;
        if (rdy && rs == 2'b11) setv[m_dph] = 1'b1;
        nm  = (m_mask | setv) & ~res;
        el  = rq & ~nm;
        win = '0;
        for (int i = N - 1; i >= 0; i--) if (el[i]) win = IW'(i);
        m_mask = nm;
        if (rdy) begin
            m_dph   = m_owner;
            m_owner = win;
        end
        @(negedge clk);
        if (exp_owner >= 0) chk(tag, int'(owner_id), exp_owner);
        chk({tag, " model"}, int'(owner_id), int'(m_owner));
        chk("R2 grant", int'(mst_grant), 1 << owner_id);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 owner", int'(owner_id), 0);
        chk("R1 grant", int'(mst_grant), 1);
        // Directed: priority, park, resume, stall, default
        cyc(4'b0010, 1, 2'b00, 4'b0000, "R4 lone requester", 1);
        cyc(4'b0010, 1, 2'b00, 4'b0000, "R4 keep", 1);
        cyc(4'b0110, 1, 2'b11, 4'b0000, "R6 split parks 1", 2);
        cyc(4'b0110, 1, 2'b00, 4'b0000, "R6 stays parked", 2);
        cyc(4'b0110, 1, 2'b00, 4'b0010, "R7 resume regains", 1);
        cyc(4'b0001, 0, 2'b00, 4'b0000, "R3 stall holds", 1);
        cyc(4'b0000, 1, 2'b00, 4'b0000, "R5 default master", 0);
        // Same-edge park and resume on master 0
        cyc(4'b0001, 1, 2'b00, 4'b0000, "R4 master0", 0);
        cyc(4'b0011, 1, 2'b11, 4'b0001, "R8 resume wins", 0);
        cyc(4'b0011, 1, 2'b00, 4'b0000, "R8 still unparked", 0);
        // Non-SPLIT codes and stalled SPLIT park nobody
        cyc(4'b0011, 1, 2'b10, 4'b0000, "R9 retry", 0);
        cyc(4'b0011, 1, 2'b01, 4'b0000, "R9 error", 0);
        cyc(4'b0011, 0, 2'b11, 4'b0000, "R9 split stalled", 0);
        cyc(4'b0011, 1, 2'b00, 4'b0000, "R9 after stalled split", 0);

        // Sweep with arithmetic stimulus against the reference model.
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            logic [N-1:0] rq, res;
            logic [1:0]   rs;
            logic         rdy;
            rq  = N'((i * 5 + i / 7) % 16);
            rdy = (i % 5) != 3;
            rs  = ((i * 7) % 6 < 2) ? 2'b11 : 2'(i % 3);
            res = ((i % 9) == 4) ? N'((i / 9) % 16) : '0;
            cyc(rq, rdy, rs, res, "R4/R6/R7 sweep", -1);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule